// File: doc/BRIEF.md
# Selectable Delay-Line Thermometer Encoder

This block is the fine-interpolation stage of a time-interval measurement path. Four tapped delay lines carry the START edge, and each line is aligned to one of four clock phases. The STOP edge freezes every tap of every line in its own flip-flop. The resulting snapshot words reach this block already registered. A 2-bit phase select, produced by the phase detector upstream, names the one line whose picture is meaningful. The block takes that line and counts how far the START edge had travelled along it. It then emits a 6-bit fine code together with an out-of-range flag and a valid strobe.

A real snapshot is not a perfect thermometer. Taps are built in slices of four, as two flip-flop pairs whose members tend to switch together. Metastability and unequal tap delays also leave isolated zeros inside the run of ones. The encoder therefore counts ones up to the first pair of adjacent zeros, so a lone zero costs one count but does not cut the code short. A new snapshot may be presented on every clock, and each result appears one cycle later.

Top module: `tdl_therm_enc`

## Requirements
- R1: Line k (k = snap_sel, 0..3) occupies snap_bus bits [k*64 +: 64], and tap 0 (the tap nearest the START entry) is the lowest bit of that field; only the selected line determines the result.
- R2: For a clean thermometer with taps 0..n-1 set and all others clear (1 <= n <= 63), fine_code equals n and fine_oor is 0.
- R3: The code is the number of ones found below the first tap position i where taps i and i+1 are both zero (tap 64 reads as zero); an isolated zero with a one after it is skipped without ending the count.
- R4: An all-zero selected line gives fine_oor = 1 with fine_code = 0, and an all-one line gives fine_oor = 1 with fine_code = 63; in all other cases fine_oor is 0.
- R5: fine_vld is high in exactly the cycle after a cycle with snap_vld high, and results follow back to back when snap_vld stays high.
- R6: When snap_vld is low, fine_code and fine_oor keep their previous values, whatever snap_bus and snap_sel do.
- R7: While reset is held and after it is released, before any snapshot, fine_vld, fine_code and fine_oor are all 0.
- R8: Changing the contents of the three unselected lines has no effect on fine_code or fine_oor.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snap_vld | input | 1 | Snapshot on snap_bus is new this cycle |
| snap_sel | input | 2 | Index of the delay line to encode |
| snap_bus | input | 256 | Four 64-tap snapshot words, line k at bits [k*64 +: 64] |
| fine_vld | output | 1 | Result strobe, one cycle after snap_vld |
| fine_code | output | 6 | Fine code, number of taps reached |
| fine_oor | output | 1 | Snapshot was all zeros or all ones |

## Verification
Every selected line is swept through every clean thermometer length from 0 to 64, with pseudo-random junk in the other three lines. This separates correct line selection and tap order from the clamped ends at both extremes. Single isolated zeros at every position inside runs of ones must lower the code by exactly one. A double zero must end the count at its first position, which tells bubble skipping apart from naive leading-one or plain popcount encoders. Even-length runs that mimic paired taps, back-to-back snapshots, and idle cycles with a changing bus test the strobe timing and the hold behaviour.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  localparam int unsigned FINE_W = 6;
  localparam int unsigned TAPS   = 1 << FINE_W;

  typedef struct packed {
    logic              oor;
    logic [FINE_W-1:0] code;
  } fine_res_t;
endpackage

// File: rtl/tdl_rst_sync.sv
module tdl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/tdl_line_mux.sv
module tdl_line_mux #(
  parameter int unsigned LINES = 4,
  parameter int unsigned TAPS  = 64,
  localparam int unsigned SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic [LINES*TAPS-1:0] bus,
  input  logic [SEL_W-1:0]      sel,
  output logic [TAPS-1:0]       line
);
  logic [TAPS-1:0] lines [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_split
    assign lines[g] = bus[g*TAPS +: TAPS];
  end

  always_comb begin
    line = '0;
    for (int k = 0; k < LINES; k++) begin
      if (SEL_W'(k) == sel) line = lines[k];
    end
  end
endmodule

// File: rtl/tdl_bubble_count.sv
module tdl_bubble_count #(
  parameter int unsigned TAPS = 64,
  localparam int unsigned CNT_W = $clog2(TAPS + 1)
) (
  input  logic [TAPS-1:0]  line,
  output logic [CNT_W-1:0] count,
  output logic             all_zero,
  output logic             all_one
);
  logic [TAPS:0] padded;
  logic          halt;

  assign padded   = {1'b0, line};
  assign all_zero = ~|line;
  assign all_one  = &line;

  // Count ones until two adjacent zeros are met.
  always_comb begin
    count = '0;
    halt  = 1'b0;
    for (int i = 0; i < TAPS; i++) begin
      if (!halt) begin
        if (!padded[i] && !padded[i+1]) begin
          halt = 1'b1;
        end else begin
          count = count + CNT_W'(padded[i]);
        end
      end
    end
  end
endmodule

// File: rtl/tdl_out_reg.sv
module tdl_out_reg
  import tdl_pkg::*;
#(
  parameter int unsigned TAPS = 64,
  localparam int unsigned CNT_W = $clog2(TAPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  input  logic             all_zero,
  input  logic             all_one,
  output logic             vld_q,
  output fine_res_t        res_q
);
  fine_res_t res_d;

  always_comb begin
    res_d = res_q;
    if (load) begin
      if (all_one) begin
        res_d.oor  = 1'b1;
        res_d.code = FINE_W'(TAPS - 1);
      end else if (all_zero) begin
        res_d.oor  = 1'b1;
        res_d.code = '0;
      end else begin
        res_d.oor  = 1'b0;
        res_d.code = count[FINE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= load;
      res_q <= res_d;
    end
  end
endmodule

// File: rtl/tdl_therm_enc.sv
module tdl_therm_enc
  import tdl_pkg::*;
#(
  parameter int unsigned LINES = 4,
  localparam int unsigned SEL_W = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int unsigned CNT_W = $clog2(TAPS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  snap_vld,
  input  logic [SEL_W-1:0]      snap_sel,
  input  logic [LINES*TAPS-1:0] snap_bus,
  output logic                  fine_vld,
  output logic [FINE_W-1:0]     fine_code,
  output logic                  fine_oor
);
  logic            rst_n_sync;
  logic [TAPS-1:0] sel_line;
  logic [CNT_W-1:0] count;
  logic            all_zero;
  logic            all_one;
  fine_res_t       res_q;

  tdl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  tdl_line_mux #(.LINES(LINES), .TAPS(TAPS)) u_mux (
    .bus  (snap_bus),
    .sel  (snap_sel),
    .line (sel_line)
  );

  tdl_bubble_count #(.TAPS(TAPS)) u_cnt (
    .line     (sel_line),
    .count    (count),
    .all_zero (all_zero),
    .all_one  (all_one)
  );

  tdl_out_reg #(.TAPS(TAPS)) u_out (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load     (snap_vld),
    .count    (count),
    .all_zero (all_zero),
    .all_one  (all_one),
    .vld_q    (fine_vld),
    .res_q    (res_q)
  );

  assign fine_code = res_q.code;
  assign fine_oor  = res_q.oor;
endmodule

// File: rtl/tdl_therm_enc_chk.sv
module tdl_therm_enc_chk
  import tdl_pkg::*;
#(
  parameter int unsigned LINES = 4,
  localparam int unsigned SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic                  clk,
  input logic                  rst_n_sync,
  input logic                  snap_vld,
  input logic [SEL_W-1:0]      snap_sel,
  input logic [LINES*TAPS-1:0] snap_bus,
  input logic                  fine_vld,
  input logic [FINE_W-1:0]     fine_code,
  input logic                  fine_oor
);
  logic [TAPS-1:0] picked;
  assign picked = snap_bus[snap_sel*TAPS +: TAPS];

  assert_vld_follows_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    snap_vld |=> fine_vld);

  assert_vld_idle_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !snap_vld |=> !fine_vld);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !snap_vld |=> ($stable(fine_code) && $stable(fine_oor)));

  assert_clamp_ends_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    fine_oor |-> (fine_code == '0 || fine_code == '1));

  assert_full_line_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (snap_vld && (&picked)) |=> (fine_oor && fine_code == '1));

  assert_empty_line_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (snap_vld && !(|picked)) |=> (fine_oor && fine_code == '0));
endmodule

bind tdl_therm_enc tdl_therm_enc_chk #(.LINES(LINES)) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .snap_vld   (snap_vld),
  .snap_sel   (snap_sel),
  .snap_bus   (snap_bus),
  .fine_vld   (fine_vld),
  .fine_code  (fine_code),
  .fine_oor   (fine_oor)
);

// File: tb/tdl_therm_enc_test.sv
module tdl_therm_enc_test;
  localparam int L = 4;
  localparam int T = 64;

  logic         clk;
  logic         rst_n;
  logic         snap_vld;
  logic [1:0]   snap_sel;
  logic [L*T-1:0] snap_bus;
  logic         fine_vld;
  logic [5:0]   fine_code;
  logic         fine_oor;

  int checks;
  int errors;
  logic [31:0] seed;

  tdl_therm_enc uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .snap_vld  (snap_vld),
    .snap_sel  (snap_sel),
    .snap_bus  (snap_bus),
    .fine_vld  (fine_vld),
    .fine_code (fine_code),
    .fine_oor  (fine_oor)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic fill_junk();
    for (int w = 0; w < L*T/32; w++) begin
      seed = nxt(seed);
      snap_bus[w*32 +: 32] = seed;
    end
  endtask

  task automatic check(input string tag, input int exp_code, input bit exp_oor,
                       input bit exp_vld);
    checks++;
    if (fine_code !== 6'(exp_code) || fine_oor !== exp_oor || fine_vld !== exp_vld) begin
      errors++;
      $display("FAIL %s: code=%0d oor=%0b vld=%0b expected code=%0d oor=%0b vld=%0b",
               tag, fine_code, fine_oor, fine_vld, exp_code, exp_oor, exp_vld);
    end
  endtask

  // Present a line on lane sel with junk elsewhere, then check one cycle later.
  task automatic run(input string tag, input int sel, input logic [T-1:0] line,
                     input int exp_code, input bit exp_oor);
    @(negedge clk);
    fill_junk();
    snap_bus[sel*T +: T] = line;
    snap_sel = 2'(sel);
    snap_vld = 1'b1;
    @(negedge clk);
    snap_vld = 1'b0;
    check(tag, exp_code, exp_oor, 1'b1);
  endtask

  function automatic logic [T-1:0] therm(input int n);
    logic [T-1:0] v;
    v = '0;
    for (int i = 0; i < T; i++) if (i < n) v[i] = 1'b1;
    return v;
  endfunction

  initial begin
    checks = 0;
    errors = 0;
    seed = 32'h1234_5678;
    rst_n = 1'b0;
    snap_vld = 1'b0;
    snap_sel = '0;
    snap_bus = '0;
    repeat (3) @(negedge clk);
    check("R7 in reset", 0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 after release", 0, 1'b0, 1'b0);

    // R1 R2 R4: every lane, every clean length
    for (int s = 0; s < L; s++) begin
      for (int n = 0; n <= T; n++) begin
        if (n == 0)      run("R4 empty line R1", s, therm(n), 0, 1'b1);
        else if (n == T) run("R4 full line R1", s, therm(n), 63, 1'b1);
        else             run("R2 clean thermometer R1", s, therm(n), n, 1'b0);
      end
    end

    // R3: isolated zero at every position inside the run
    for (int n = 2; n < T; n += 7) begin
      for (int b = 0; b < n - 1; b++) begin
        logic [T-1:0] v;
        v = therm(n);
        v[b] = 1'b0;
        run("R3 isolated bubble", b % L, v, n - 1, 1'b0);
      end
    end

    // R3: a double zero ends the count at its first position
    for (int b = 1; b < T - 3; b += 3) begin
      logic [T-1:0] v;
      v = therm(T - 1);
      v[b] = 1'b0;
      v[b+1] = 1'b0;
      run("R3 double zero stops count", (b / 3) % L, v, b, 1'b0);
    end
    begin
      logic [T-1:0] v;
      v = '0;
      v[40] = 1'b1;
      run("R3 leading double zero", 2, v, 0, 1'b0);
    end

    // R2: paired-tap even lengths on lane 3
    for (int n = 2; n < T; n += 4) run("R2 paired taps", 3, therm(n), n, 1'b0);

    // R5: back to back snapshots
    @(negedge clk);
    snap_bus = '0;
    snap_bus[0*T +: T] = therm(5);
    snap_sel = 2'd0;
    snap_vld = 1'b1;
    @(negedge clk);
    check("R5 back to back first", 5, 1'b0, 1'b1);
    snap_bus[1*T +: T] = therm(33);
    snap_sel = 2'd1;
    @(negedge clk);
    check("R5 back to back second", 33, 1'b0, 1'b1);
    snap_vld = 1'b0;

    // R6 R8: idle cycles with changing bus hold the result
    for (int k = 0; k < 8; k++) begin
      fill_junk();
      snap_sel = 2'(k);
      @(negedge clk);
      check("R6 hold while idle", 33, 1'b0, 1'b0);
    end

    // R8: junk in other lanes changes nothing
    for (int k = 0; k < 16; k++) run("R8 unselected lanes ignored", 2, therm(17), 17, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule